// File: doc/BRIEF.md
# MII Management (Clause-22) Bus Master

This block is a memory-mapped master for the two-wire PHY management bus. It drives the management clock (MDC) and the bidirectional data line (MDIO, split here into an output, an output enable and an input) to run Clause-22 read and write frames. Each frame is a 32-bit preamble of ones, start code 01, a two-bit opcode, a 5-bit PHY address, a 5-bit register number, a two-bit turnaround and 16 data bits. All fields go out most significant bit first.

Software talks to the block through a simple word-indexed register port. It loads the PHY and register address first. It then either writes a data word to start a write frame, or raises the read request bit to start a read frame. It polls the indication register until both the busy flag and the not-valid flag are clear, and then takes the read data. The MDC rate comes from the system clock through a divider that a clock-select field picks. Setting a self-clearing reset bit in the configuration register aborts any frame that is in progress.

Register indexes (`bus_idx`): 0 configuration, 1 command, 2 address, 3 write data, 4 read data, 5 indication. Indexes 6 and 7 are unmapped.

Top module: `miim_master`

## Requirements
- R1: After `rst`, these hold: configuration reads 0x00000007 (clock-select field in bits 2:0 = CSEL_INIT), indication reads 0, read data reads 0, `mdc` is 1 and `mdio_oe` is 0.
- R2: The address register keeps the PHY address in bits 12:8 and the register number in bits 4:0. Every other bit reads back as 0.
- R3: A write to index 3 while idle starts a write frame. The frame is 64 bits, MSB first: 32 ones, 01, opcode 01, PHY[4:0], REG[4:0], 10, then write data bits 15:0. The master drives all 64 bits. MDIO changes only as MDC falls, and MDC rises exactly 64 times per frame.
- R4: A read frame uses opcode 10. The master drives bits 0 to 45 and releases MDIO (`mdio_oe`=0) from the turnaround onward. It samples the 16 data bits on rising MDC, and the result appears in bits 15:0 of the read-data register.
- R5: A read starts only when a write to index 1 takes bit 0 from 0 to 1. Writing 1 again while bit 0 is already 1 starts nothing, so software clears the bit before each new read.
- R6: Indication bit 0 (busy) reads 1 from the cycle after the starting write until the last rising MDC edge, which comes 128 half periods after the start. Indication bit 2 (not-valid) is set by a read start and clears one cycle after busy, once the data is stored. Write frames do not change bit 2.
- R7: MDC half period = (clock-select + 1) * DIV_STEP system clocks. The value is taken when the frame starts. MDC stays high whenever no frame runs.
- R8: Writes to index 3 and read requests made while busy start no frame and leave the running frame unchanged.
- R9: Writing 1 to configuration bit 31 aborts any frame in the next cycle. It clears busy and not-valid, sets MDC high and releases MDIO. The same write loads the clock-select field, and bit 31 always reads 0.
- R10: A register read returns its data on `bus_rdata` in the cycle after `bus_rd_en`. The write-data register reads back the full 32-bit word, and unmapped indexes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_idx | input | 3 | Register index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable, 1 = master drives |
| mdio_in | input | 1 | MDIO value seen on the pin |

## Verification
The embedded assertions check on every cycle that MDC is high and MDIO is released whenever the engine is idle, and that MDC toggles only on a divider tick. They also check that the driven MDIO bit moves only on a falling MDC, that the master has let go of the line by turnaround on reads, and that a start raises busy while a soft reset clears it. Only the bench scenarios can show the frame contents bit for bit, the half period for each clock-select value, the exact cycle in which busy and not-valid drop, and the read data taken from a modelled PHY. The same holds for starts that must be ignored while busy or while the read bit is already set.

// File: rtl/miim_pkg.sv
package miim_pkg;

  // register indexes on the word port
  localparam logic [2:0] RI_CFG   = 3'd0;
  localparam logic [2:0] RI_CMD   = 3'd1;
  localparam logic [2:0] RI_ADDR  = 3'd2;
  localparam logic [2:0] RI_WDATA = 3'd3;
  localparam logic [2:0] RI_RDATA = 3'd4;
  localparam logic [2:0] RI_IND   = 3'd5;

  // frame geometry
  localparam int PRE_BITS   = 32;
  localparam int HDR_BITS   = 14;  // start, opcode, phy, register
  localparam int TA_BITS    = 2;
  localparam int DATA_BITS  = 16;
  localparam int ADR_BITS   = 5;
  localparam int FRAME_BITS = PRE_BITS + HDR_BITS + TA_BITS + DATA_BITS;
  localparam int TA_POS     = PRE_BITS + HDR_BITS;
  localparam int DATA_POS   = TA_POS + TA_BITS;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic                 rd;
    logic [ADR_BITS-1:0]  phy;
    logic [ADR_BITS-1:0]  regad;
    logic [DATA_BITS-1:0] data;
  } miim_req_t;

  function automatic logic [FRAME_BITS-1:0] frame_word(input miim_req_t r);
    logic [1:0] op;
    op = r.rd ? 2'b10 : 2'b01;
    frame_word = {{PRE_BITS{1'b1}}, 2'b01, op, r.phy, r.regad, 2'b10, r.data};
  endfunction

endpackage

// File: rtl/miim_mdc_div.sv
module miim_mdc_div #(
  parameter int HALF_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half_len,
  output logic              tick
);

  logic [HALF_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half_len - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + HALF_W'(1);
  end

  // R7: the count never passes the chosen half period
  a_r7_count_in_range: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < half_len));

endmodule

// File: rtl/miim_frame_engine.sv
module miim_frame_engine
  import miim_pkg::*;
#(
  parameter int CSEL_W   = 3,
  parameter int DIV_STEP = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 abort,
  input  logic                 start,
  input  miim_req_t            req,
  input  logic [CSEL_W-1:0]    csel,
  input  logic                 mdio_in,
  output logic                 mdc,
  output logic                 mdio_out,
  output logic                 mdio_oe,
  output logic                 busy,
  output logic                 rd_done,
  output logic [DATA_BITS-1:0] rd_data
);

  localparam int HALF_MAX = (1 << CSEL_W) * DIV_STEP;
  localparam int HALF_W   = $clog2(HALF_MAX + 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic                  run_q, rd_q, mdc_q, oe_q, dout_q, mdio_q, done_q;
  logic [FRAME_BITS-1:0] shf_q;
  logic [IDX_W-1:0]      idx_q;
  logic [DATA_BITS-1:0]  cap_q;
  logic [HALF_W-1:0]     half_q;
  logic                  tick;

  miim_mdc_div #(.HALF_W(HALF_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (run_q),
    .half_len (half_q),
    .tick     (tick)
  );

  // input register on the shared data line
  always_ff @(posedge clk) begin
    if (rst) mdio_q <= 1'b1;
    else     mdio_q <= mdio_in;
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      run_q  <= 1'b0;
      rd_q   <= 1'b0;
      mdc_q  <= 1'b1;
      oe_q   <= 1'b0;
      dout_q <= 1'b1;
      done_q <= 1'b0;
      idx_q  <= '0;
      shf_q  <= '0;
      half_q <= HALF_W'(DIV_STEP);
      if (rst) cap_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run_q) begin
        if (start) begin
          run_q  <= 1'b1;
          rd_q   <= req.rd;
          shf_q  <= frame_word(req);
          idx_q  <= '0;
          half_q <= HALF_W'((int'(csel) + 1) * DIV_STEP);
        end
      end else if (tick) begin
        if (mdc_q) begin
          // falling edge: present the next bit
          mdc_q  <= 1'b0;
          dout_q <= shf_q[FRAME_BITS-1];
          shf_q  <= {shf_q[FRAME_BITS-2:0], 1'b0};
          oe_q   <= !(rd_q && (idx_q >= TA_IDX));
        end else begin
          // rising edge: the far end samples, the master samples read data
          mdc_q <= 1'b1;
          if (rd_q && (idx_q >= DATA_IDX))
            cap_q <= {cap_q[DATA_BITS-2:0], mdio_q};
          if (idx_q == LAST_IDX) begin
            run_q  <= 1'b0;
            oe_q   <= 1'b0;
            dout_q <= 1'b1;
            done_q <= rd_q;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
      end
    end
  end

  assign mdc      = mdc_q;
  assign mdio_out = dout_q;
  assign mdio_oe  = oe_q;
  assign busy     = run_q;
  assign rd_done  = done_q;
  assign rd_data  = cap_q;

  // R7: clock idles high between frames
  a_r7_mdc_idle_high: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> mdc_q);

  // R1 / R9: line released whenever no frame runs
  a_r1_released_when_idle: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> !oe_q);

  // R4: read frames let go of the line from turnaround on
  a_r4_released_in_turnaround: assert property (@(posedge clk) disable iff (rst)
    (run_q && rd_q && !mdc_q && (idx_q >= TA_IDX)) |-> !oe_q);

  // R7: clock moves only on a divider tick
  a_r7_mdc_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    (run_q && !tick && !abort) |=> $stable(mdc_q));

  // R3: driven bit changes only together with a falling clock
  a_r3_mdio_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    (run_q && (dout_q != $past(dout_q))) |-> $fell(mdc_q));

  // R7: half period is held for the whole frame
  a_r7_half_len_held: assert property (@(posedge clk) disable iff (rst)
    (run_q && !abort) |=> (!run_q || $stable(half_q)));

endmodule

// File: rtl/miim_regs.sv
module miim_regs
  import miim_pkg::*;
#(
  parameter int              CSEL_W    = 3,
  parameter logic [CSEL_W-1:0] CSEL_INIT = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr_en,
  input  logic                 bus_rd_en,
  input  logic [2:0]           bus_idx,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic                 eng_busy,
  input  logic                 rd_done,
  input  logic [DATA_BITS-1:0] rd_data,
  output logic                 start,
  output miim_req_t            req,
  output logic [CSEL_W-1:0]    csel,
  output logic                 soft_rst
);

  localparam int PHY_LSB  = 8;
  localparam int RST_BIT  = 31;
  localparam int BUSY_BIT = 0;
  localparam int NV_BIT   = 2;

  logic [CSEL_W-1:0]    csel_q;
  logic                 cmd_rd_q;
  logic [ADR_BITS-1:0]  phy_q, reg_q;
  logic [31:0]          wdat_q;
  logic [DATA_BITS-1:0] rdat_q;
  logic                 nv_q;
  logic                 wr_cfg, wr_cmd, wr_addr, wr_wdata;
  logic                 go_write, go_read;
  logic [31:0]          rd_mux;

  assign wr_cfg   = bus_wr_en && (bus_idx == RI_CFG);
  assign wr_cmd   = bus_wr_en && (bus_idx == RI_CMD);
  assign wr_addr  = bus_wr_en && (bus_idx == RI_ADDR);
  assign wr_wdata = bus_wr_en && (bus_idx == RI_WDATA);

  assign soft_rst = wr_cfg && bus_wdata[RST_BIT];
  assign go_write = wr_wdata && !eng_busy;
  assign go_read  = wr_cmd && bus_wdata[0] && !cmd_rd_q && !eng_busy;
  assign start    = go_write || go_read;

  always_comb begin
    req.rd    = go_read;
    req.phy   = phy_q;
    req.regad = reg_q;
    req.data  = bus_wdata[DATA_BITS-1:0];
  end

  assign csel = csel_q;

  always_comb begin
    rd_mux = '0;
    case (bus_idx)
      RI_CFG:   rd_mux[CSEL_W-1:0] = csel_q;
      RI_CMD:   rd_mux[0] = cmd_rd_q;
      RI_ADDR: begin
        rd_mux[PHY_LSB +: ADR_BITS] = phy_q;
        rd_mux[ADR_BITS-1:0]        = reg_q;
      end
      RI_WDATA: rd_mux = wdat_q;
      RI_RDATA: rd_mux[DATA_BITS-1:0] = rdat_q;
      RI_IND: begin
        rd_mux[BUSY_BIT] = eng_busy;
        rd_mux[NV_BIT]   = nv_q;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csel_q    <= CSEL_INIT;
      cmd_rd_q  <= 1'b0;
      phy_q     <= '0;
      reg_q     <= '0;
      wdat_q    <= '0;
      rdat_q    <= '0;
      nv_q      <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_cfg)   csel_q   <= bus_wdata[CSEL_W-1:0];
      if (wr_cmd)   cmd_rd_q <= bus_wdata[0];
      if (wr_addr) begin
        phy_q <= bus_wdata[PHY_LSB +: ADR_BITS];
        reg_q <= bus_wdata[ADR_BITS-1:0];
      end
      if (wr_wdata) wdat_q <= bus_wdata;
      if (rd_done)  rdat_q <= rd_data;
      if (soft_rst)     nv_q <= 1'b0;
      else if (go_read) nv_q <= 1'b1;
      else if (rd_done) nv_q <= 1'b0;
      if (bus_rd_en) bus_rdata <= rd_mux;
    end
  end

  // R6: an accepted start shows as busy in the next cycle
  a_r6_busy_follows_start: assert property (@(posedge clk) disable iff (rst)
    start |=> eng_busy);

  // R9: soft reset leaves no frame and no pending read
  a_r9_abort_clears: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!eng_busy && !nv_q));

  // R9: the reset bit never reads back as set
  a_r9_reset_bit_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && (bus_idx == RI_CFG)) |=> !bus_rdata[RST_BIT]);

  // R6: stored read data ends the not-valid window
  a_r6_nv_clears_on_done: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !go_read) |=> !nv_q);

endmodule

// File: rtl/miim_master.sv
module miim_master
  import miim_pkg::*;
#(
  parameter int                CSEL_W    = 3,
  parameter logic [CSEL_W-1:0] CSEL_INIT = '1,
  parameter int                DIV_STEP  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr_en,
  input  logic        bus_rd_en,
  input  logic [2:0]  bus_idx,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);

  logic                 eng_busy, rd_done, start, soft_rst;
  logic [DATA_BITS-1:0] rd_data;
  logic [CSEL_W-1:0]    csel;
  miim_req_t            req;

  miim_regs #(.CSEL_W(CSEL_W), .CSEL_INIT(CSEL_INIT)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_idx   (bus_idx),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .eng_busy  (eng_busy),
    .rd_done   (rd_done),
    .rd_data   (rd_data),
    .start     (start),
    .req       (req),
    .csel      (csel),
    .soft_rst  (soft_rst)
  );

  miim_frame_engine #(.CSEL_W(CSEL_W), .DIV_STEP(DIV_STEP)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .abort    (soft_rst),
    .start    (start),
    .req      (req),
    .csel     (csel),
    .mdio_in  (mdio_in),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .busy     (eng_busy),
    .rd_done  (rd_done),
    .rd_data  (rd_data)
  );

endmodule

// File: tb/miim_master_test.sv
module miim_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_STEP   = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [2:0]  bus_idx = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  miim_master #(.CSEL_W(3), .CSEL_INIT(3'd7), .DIV_STEP(DIV_STEP)) uut (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  // ---------------- line monitor and PHY model ----------------
  int          rise_cnt = 0, fall_cnt = 0, phy_base = 0;
  logic [63:0] mon_d = '0, mon_oe = '0;
  logic [15:0] phy_word = '0;
  logic        pre_d = 1'b1, pre_oe = 1'b0;
  time         t_rise = 0, t_fall = 0;

  always @(negedge clk) begin
    pre_d  = mdio_out;
    pre_oe = mdio_oe;
  end

  always @(posedge mdc) begin
    mon_d  = {mon_d[62:0], pre_d};
    mon_oe = {mon_oe[62:0], pre_oe};
    rise_cnt++;
    t_rise = $time;
  end

  always @(negedge mdc) begin
    int k;
    k = fall_cnt - phy_base;
    fall_cnt++;
    t_fall = $time;
    if (k >= 48 && k <= 63) mdio_in = phy_word[63-k];
    else                    mdio_in = 1'b1;
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_idx = i; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] i, output logic [31:0] d);
    bus_rd_en = 1'b1; bus_idx = i;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [63:0] exp_frame(input bit is_rd, input logic [4:0] p,
                                           input logic [4:0] r, input logic [15:0] d);
    exp_frame = {32'hFFFF_FFFF, 2'b01, (is_rd ? 2'b10 : 2'b01), p, r, 2'b10, d};
  endfunction

  task automatic write_frame(input int cs, input logic [4:0] p, input logic [4:0] r,
                             input logic [15:0] d);
    int h, rb;
    logic [31:0] v;
    h = (cs + 1) * DIV_STEP;
    wr(3'd0, 32'(cs));
    wr(3'd2, {19'b0, p, 3'b0, r});
    rb = rise_cnt;
    wr(3'd3, {16'h0, d});
    rd(3'd5, v); check("R6 busy right after write start", v, 64'h1);
    repeat (128*h - 2) @(negedge clk);
    rd(3'd5, v); check("R6 busy in last half period", v, 64'h1);
    rd(3'd5, v); check("R6 idle after write frame", v, 64'h0);
    check("R3 rising MDC count", 64'(rise_cnt - rb), 64'd64);
    check("R3 write frame bits", mon_d, exp_frame(0, p, r, d));
    check("R3 driven for all bits", mon_oe, '1);
    check("R7 MDC half period", 64'((t_rise - t_fall) / CLK_PERIOD), 64'(h));
    check("R7 MDC high after frame", {63'b0, mdc}, 64'h1);
  endtask

  task automatic read_frame(input int cs, input logic [4:0] p, input logic [4:0] r,
                            input logic [15:0] d);
    int h, rb;
    logic [31:0] v;
    logic [63:0] e;
    h = (cs + 1) * DIV_STEP;
    phy_word = d;
    wr(3'd0, 32'(cs));
    wr(3'd2, {19'b0, p, 3'b0, r});
    wr(3'd1, 32'h0);
    phy_base = fall_cnt;
    rb = rise_cnt;
    wr(3'd1, 32'h1);
    rd(3'd5, v); check("R6 busy and not-valid after read start", v, 64'h5);
    repeat (128*h - 2) @(negedge clk);
    rd(3'd5, v); check("R6 busy in last read half period", v, 64'h5);
    rd(3'd5, v); check("R6 not-valid lags busy by one cycle", v, 64'h4);
    rd(3'd4, v); check("R4 read data", v, {48'h0, d});
    rd(3'd5, v); check("R6 all clear after read", v, 64'h0);
    e = exp_frame(1, p, r, 16'h0);
    check("R4 read header bits", {18'h0, mon_d[63:18]}, {18'h0, e[63:18]});
    check("R4 released from turnaround", mon_oe, 64'hFFFF_FFFF_FFFC_0000);
    check("R4 rising MDC count", 64'(rise_cnt - rb), 64'd64);
    check("R7 read MDC half period", 64'((t_rise - t_fall) / CLK_PERIOD), 64'(h));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] v;
    int rb;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, v); check("R1 configuration reset value", v, 64'h7);
    rd(3'd5, v); check("R1 indication reset value", v, 64'h0);
    rd(3'd4, v); check("R1 read data reset value", v, 64'h0);
    check("R1 MDC high and MDIO released", {62'b0, mdc, mdio_oe}, 64'h2);

    // R2 address fields, R10 readback and unmapped
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); check("R2 address fields only", v, 64'h0000_1F1F);
    wr(3'd2, 32'h0000_0A15);
    rd(3'd2, v); check("R2 address readback", v, 64'h0000_0A15);
    rd(3'd6, v); check("R10 unmapped index 6 reads 0", v, 64'h0);
    rd(3'd7, v); check("R10 unmapped index 7 reads 0", v, 64'h0);

    // R3/R7 sweep of every clock-select value
    for (int cs = 0; cs < 8; cs++)
      write_frame(cs, 5'(cs * 3 + 1), 5'(31 - cs * 2), 16'(16'hA5C3 ^ (cs * 16'h1111)));
    rd(3'd3, v); check("R10 write data reads back", v, 64'(32'h0000_A5C3 ^ 32'(7 * 16'h1111)));

    // R4 read patterns
    read_frame(0, 5'h01, 5'h02, 16'hA5C3);
    read_frame(1, 5'h1F, 5'h1F, 16'h0001);
    read_frame(2, 5'h10, 5'h00, 16'h8000);
    read_frame(0, 5'h00, 5'h11, 16'hFFFF);
    read_frame(7, 5'h0B, 5'h05, 16'h0000);

    // R5 read bit already set: no new frame
    rb = rise_cnt;
    wr(3'd1, 32'h1);
    rd(3'd5, v); check("R5 repeated read request ignored", v, 64'h0);
    repeat (40) @(negedge clk);
    check("R5 no MDC activity", 64'(rise_cnt - rb), 64'd0);

    // R8 starts while busy
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h0);
    wr(3'd2, {19'b0, 5'h03, 3'b0, 5'h04});
    rb = rise_cnt;
    wr(3'd3, 32'h0000_1357);
    wr(3'd3, 32'h0000_FFFF);
    wr(3'd1, 32'h1);
    repeat (300) @(negedge clk);
    check("R8 frame count unchanged by busy starts", 64'(rise_cnt - rb), 64'd64);
    check("R8 running frame kept its data", mon_d, exp_frame(0, 5'h03, 5'h04, 16'h1357));
    rd(3'd5, v); check("R8 idle afterwards", v, 64'h0);
    wr(3'd1, 32'h0);

    // R9 soft reset during a write
    wr(3'd0, 32'h3);
    wr(3'd3, 32'h0000_00FF);
    repeat (100) @(negedge clk);
    wr(3'd0, 32'h8000_0001);
    rd(3'd5, v); check("R9 busy cleared by soft reset", v, 64'h0);
    check("R9 MDC high, MDIO released", {62'b0, mdc, mdio_oe}, 64'h2);
    rb = rise_cnt;
    repeat (50) @(negedge clk);
    check("R9 no MDC after abort", 64'(rise_cnt - rb), 64'd0);
    rd(3'd0, v); check("R9 reset bit self-clears, select loaded", v, 64'h1);

    // R9 soft reset during a read
    wr(3'd1, 32'h1);
    repeat (30) @(negedge clk);
    wr(3'd0, 32'h8000_0000);
    rd(3'd5, v); check("R9 not-valid cleared by soft reset", v, 64'h0);
    wr(3'd1, 32'h0);

    // R9 recovery: full frames after an abort
    read_frame(1, 5'h15, 5'h0A, 16'h5AA5);
    write_frame(0, 5'h1E, 5'h01, 16'hC001);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule